// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is the transmit side of a network DMA engine. Software builds a ring of 32-byte transmit descriptors in host memory, marks each one as owned by hardware, and writes a poll-demand strobe. The walker then visits descriptors starting at its current-descriptor pointer. It fetches the control/status word, the size word and the buffer address of each descriptor. For every descriptor that hardware owns, it reads the buffer contents word by word and hands them out one byte at a time on a valid/ready stream. It then writes the control/status word back with ownership cleared and moves to the next descriptor. The walk ends at the first descriptor that software still owns.

A descriptor's layout inside its 32 bytes is fixed. Word 0 (offset 0) is control/status. Word 1 (offset 4) carries the primary buffer size in bits [11:0] and the secondary size in bits [27:16]; all other bits of word 1 are ignored. Word 2 (offset 8) is the primary buffer address. The remaining words are never read or written. The byte stream follows the usual valid/ready rules. A byte moves on a clock edge where both `tx_valid` and `tx_ready` are high. While `tx_valid` is high and `tx_ready` is low, the byte and its end marker hold still. While a byte is waiting, no memory read is issued, so back-pressure on the stream stalls the buffer reads directly.

The memory master carries one access at a time. A request stays asserted with a stable address, direction and write data until `mem_ready` is seen high on a clock edge. A write is complete at that edge. A read is answered by a one-cycle `mem_rvalid` pulse at least one cycle later. Three sticky flags report the end of a frame and an odd segment size. Software clears each flag by writing a one to its clear bit.

Top module: `tx_ring_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `mem_req` and `tx_valid` are low and all three status flags are low. While idle, no request and no byte is produced.
- R2: A `poll_wr` pulse while idle starts a walk, and the first access is a read of offset 0 of the descriptor at the current pointer. A `base_wr` pulse loads both the ring base and the current pointer with `base_addr`.
- R3: A fetched control/status word with bit 31 (ownership) at 0 ends the walk. That descriptor produces no stream byte and no memory write, and the pointer stays on it for the next walk.
- R4: The segment length is word1[11:0] + word1[27:16]. That many consecutive bytes are streamed, starting at the primary buffer address, which may be unaligned. The byte at address A comes from bits [8*A[1:0]+7 : 8*A[1:0]] of the memory word at A with its two low bits cleared.
- R5: `tx_last` is high only with the final byte of a segment whose control/status bit 29 (last segment) is set. A zero-length segment streams nothing.
- R6: After its data has gone out, each owned descriptor gets exactly one write, to its offset 0. The written value is its control/status word with bit 31 cleared and every other bit unchanged.
- R7: After the write-back, the pointer reloads the ring base if control/status bit 21 (end of ring) is set; otherwise it advances by 32.
- R8: The write-back of a last-segment descriptor sets both `stat_ti` and `stat_nis`. Flags are sticky until `stat_clr` bit 0 (ti), bit 1 (nis) or bit 2 (err) is pulsed. A set in the same cycle as a clear wins.
- R9: A primary size above 2048 or a non-zero secondary size sets `stat_err`, and the segment is still streamed and written back normally.
- R10: While `tx_valid` is high and `tx_ready` low, `tx_data` and `tx_last` hold. No memory request is made while a byte is offered.
- R11: A `poll_wr` during a walk, including in the cycle the ending descriptor is seen, causes exactly one extra walk after the current one. Several such pulses collapse into one.
- R12: Once `mem_req` is raised, it holds with stable `mem_addr`, `mem_we` and `mem_wdata` until accepted by `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_wr | input | 1 | Load ring base and current pointer |
| base_addr | input | AW | Value loaded by base_wr |
| poll_wr | input | 1 | Poll-demand strobe |
| stat_clr | input | 3 | Write-one-to-clear for err, nis, ti (bits 2..0) |
| stat_ti | output | 1 | Sticky: a last-segment descriptor completed |
| stat_nis | output | 1 | Sticky: normal summary |
| stat_err | output | 1 | Sticky: odd segment size seen |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted this edge |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Stream sink ready |

## Verification
Two events can land in the same cycle: a new poll demand, and the fetch of the software-owned descriptor that ends a walk. To provoke this, the bench's memory model raises `poll_wr` in exactly the cycle it returns a control word with bit 31 clear. The bench then counts how often that stopping descriptor's offset 0 is read; it expects two reads, one per walk. Random memory latency, random `mem_ready` and bursts of stream back-pressure move the ending cycle around. Late polls sent during a longer walk cover the latched case.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int WORD_W     = 32;
  localparam int LANES      = WORD_W / 8;
  localparam int LANE_W     = $clog2(LANES);
  localparam int DESC_BYTES = 32;
  localparam int SIZE_W     = 12;
  localparam int LEN_W      = SIZE_W + 1;
  localparam int SIZE2_LSB  = 16;
  localparam int OWN_POS    = 31;
  localparam int LAST_POS   = 29;
  localparam int WRAP_POS   = 21;
  localparam int BIG_LIMIT  = 2048;
  localparam int STAT_N     = 3;
  localparam int ST_TI      = 0;
  localparam int ST_NIS     = 1;
  localparam int ST_ERR     = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_DRD, S_DWT, S_BRD, S_BWT, S_EMIT, S_WB
  } walk_st_t;

  function automatic logic [LEN_W-1:0] seg_len(input logic [WORD_W-1:0] w1);
    return {1'b0, w1[SIZE_W-1:0]} + {1'b0, w1[SIZE2_LSB +: SIZE_W]};
  endfunction

  function automatic logic size_odd(input logic [WORD_W-1:0] w1);
    return (int'(w1[SIZE_W-1:0]) > BIG_LIMIT) || (w1[SIZE2_LSB +: SIZE_W] != '0);
  endfunction
endpackage

// File: rtl/txr_ptr.sv
module txr_ptr
  import txr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_wr,
  input  logic [AW-1:0] base_data,
  input  logic          adv,
  input  logic          wrap,
  output logic [AW-1:0] cur
);
  logic [AW-1:0] base_q, cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (base_wr) begin
      base_q <= base_data;
      cur_q  <= base_data;
    end else if (adv) begin
      cur_q <= wrap ? base_q : cur_q + AW'(DESC_BYTES);
    end
  end

  assign cur = cur_q;

  // R7: plain advance steps one descriptor
  p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !wrap && !base_wr |=> cur_q == $past(cur_q) + AW'(DESC_BYTES));
  // R7: end-of-ring returns to the base
  p_ptr_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adv && wrap && !base_wr |=> cur_q == $past(base_q));
  // R2: base write loads the pointer
  p_base_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |=> cur_q == $past(base_data));
endmodule

// File: rtl/txr_lane_sel.sv
module txr_lane_sel
  import txr_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [LANE_W-1:0] lane,
  output logic [7:0]        byte_o
);
  logic [7:0] lanes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = word[8*g +: 8];
  end

  assign byte_o = lanes[lane];
endmodule

// File: rtl/txr_stat.sv
module txr_stat #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr) | set;
  end

  // R8: a set lands even against a clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((q & $past(set)) == $past(set)));
  // R8: flags stay until cleared
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (q != '0) |=> (($past(q & ~clr) & ~q) == '0));
endmodule

// File: rtl/tx_ring_walker.sv
module tx_ring_walker
  import txr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_wr,
  input  logic [AW-1:0]     base_addr,
  input  logic              poll_wr,
  input  logic [2:0]        stat_clr,
  output logic              stat_ti,
  output logic              stat_nis,
  output logic              stat_err,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready
);
  localparam logic [WORD_W-1:0] OWN_MASK = WORD_W'(1) << OWN_POS;

  walk_st_t           st;
  logic [1:0]         widx;
  logic [WORD_W-1:0]  ctl;
  logic [LEN_W-1:0]   rem;
  logic [AW-1:0]      baddr;
  logic [WORD_W-1:0]  word_q;
  logic               pend;
  logic [AW-1:0]      cur;
  logic               end_walk;
  logic               adv;
  logic [STAT_N-1:0]  st_set;
  logic [STAT_N-1:0]  st_q;

  assign end_walk = (st == S_DWT) && mem_rvalid && (widx == 2'd0) && !mem_rdata[OWN_POS];
  assign adv      = (st == S_WB) && mem_ready;

  txr_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_data(base_addr),
    .adv(adv), .wrap(ctl[WRAP_POS]), .cur(cur)
  );

  txr_lane_sel u_lane (
    .word(word_q), .lane(baddr[LANE_W-1:0]), .byte_o(tx_data)
  );

  always_comb begin
    st_set          = '0;
    st_set[ST_TI]   = adv && ctl[LAST_POS];
    st_set[ST_NIS]  = adv && ctl[LAST_POS];
    st_set[ST_ERR]  = (st == S_DWT) && mem_rvalid && (widx == 2'd1) && size_odd(mem_rdata);
  end

  txr_stat #(.N(STAT_N)) u_stat (
    .clk(clk), .rst_n(rst_n), .set(st_set), .clr(stat_clr), .q(st_q)
  );

  assign stat_ti  = st_q[ST_TI];
  assign stat_nis = st_q[ST_NIS];
  assign stat_err = st_q[ST_ERR];
  assign busy     = (st != S_IDLE);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      S_DRD: begin
        mem_req  = 1'b1;
        mem_addr = cur + AW'({widx, 2'b00});
      end
      S_BRD: begin
        mem_req  = 1'b1;
        mem_addr = {baddr[AW-1:LANE_W], {LANE_W{1'b0}}};
      end
      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur;
        mem_wdata = ctl & ~OWN_MASK;
      end
      default: ;
    endcase
  end

  assign tx_valid = (st == S_EMIT);
  assign tx_last  = (st == S_EMIT) && ctl[LAST_POS] && (rem == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      widx   <= '0;
      ctl    <= '0;
      rem    <= '0;
      baddr  <= '0;
      word_q <= '0;
      pend   <= 1'b0;
    end else begin
      if (poll_wr && (st != S_IDLE) && !end_walk) pend <= 1'b1;
      case (st)
        S_IDLE: if (poll_wr) begin
          st   <= S_DRD;
          widx <= 2'd0;
        end
        S_DRD: if (mem_ready) st <= S_DWT;
        S_DWT: if (mem_rvalid) begin
          case (widx)
            2'd0: begin
              if (!mem_rdata[OWN_POS]) begin
                pend <= 1'b0;
                st   <= (pend || poll_wr) ? S_DRD : S_IDLE;
              end else begin
                ctl  <= mem_rdata;
                widx <= 2'd1;
                st   <= S_DRD;
              end
            end
            2'd1: begin
              rem  <= seg_len(mem_rdata);
              widx <= 2'd2;
              st   <= S_DRD;
            end
            default: begin
              baddr <= AW'(mem_rdata);
              widx  <= 2'd0;
              st    <= (rem == '0) ? S_WB : S_BRD;
            end
          endcase
        end
        S_BRD: if (mem_ready) st <= S_BWT;
        S_BWT: if (mem_rvalid) begin
          word_q <= mem_rdata;
          st     <= S_EMIT;
        end
        S_EMIT: if (tx_ready) begin
          baddr <= baddr + AW'(1);
          rem   <= rem - LEN_W'(1);
          if (rem == LEN_W'(1))                 st <= S_WB;
          else if (baddr[LANE_W-1:0] == '1)     st <= S_BRD;
        end
        S_WB: if (mem_ready) begin
          st   <= S_DRD;
          widx <= 2'd0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R12: request held stable until accepted
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R10: offered byte holds under back-pressure
  p_stream_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
  // R10: no memory traffic while a byte waits
  p_no_req_in_emit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !mem_req);
  // R6: write-back always returns ownership
  p_wb_own_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[OWN_POS]);
  // R3: ending descriptor is never written
  p_end_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    end_walk |=> !(mem_req && mem_we));
  // R1: idle walker is silent
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !tx_valid);
endmodule

// File: tb/sim_tx_ring_walker.sv
module sim_tx_ring_walker;
  localparam int AW = 32;
  localparam logic [31:0] RING = 32'h100;
  localparam int SLOTS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        base_wr = 1'b0;
  logic [31:0] base_addr = '0;
  logic        poll_a = 1'b0, poll_b = 1'b0;
  wire         poll_wr = poll_a | poll_b;
  logic [2:0]  stat_clr = '0;
  logic        mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        tx_ready = 1'b0;
  wire         stat_ti, stat_nis, stat_err, busy, mem_req, mem_we, tx_valid, tx_last;
  wire  [31:0] mem_addr, mem_wdata;
  wire  [7:0]  tx_data;

  tx_ring_walker #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_addr(base_addr), .poll_wr(poll_wr),
    .stat_clr(stat_clr), .stat_ti(stat_ti), .stat_nis(stat_nis), .stat_err(stat_err), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  logic [31:0] mem [0:1023];
  int total = 0, bad = 0, cyc = 0;

  bit          lat_on = 0, poe = 0;
  int          lat = 0, hold_low = 0;
  logic [9:0]  ridx = '0;
  int          wr_cnt = 0, stop_reads = 0, gn = 0;
  logic [31:0] watch = '0, last_w0 = '0;
  logic [7:0]  gb [0:4095];
  bit          gl [0:4095];
  logic [7:0]  eb [0:4095];
  bit          el [0:4095];
  int          en = 0, ecount = 0;
  logic [31:0] ep [0:15];
  logic [31:0] ectl [0:15];
  logic [31:0] estop = '0, mptr = '0;
  bit          exp_ti = 0, exp_err = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mb(input logic [31:0] a);
    return mem[a[11:2]][{a[1:0], 3'b000} +: 8];
  endfunction

  // memory, stream sink and coincident poll model
  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    poll_b = 1'b0;
    if (lat_on) begin
      if (lat == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata = mem[ridx];
        lat_on = 0;
        if (poe && ridx < 10'h100 && ridx[2:0] == 3'd0 && !mem[ridx][31]) begin
          poll_b = 1'b1;
          poe = 0;
        end
      end else lat--;
    end
    mem_ready = ($urandom % 4) != 0;
    if (mem_req && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr[11:2]] = mem_wdata;
        wr_cnt++;
      end else begin
        lat_on = 1;
        ridx = mem_addr[11:2];
        lat = $urandom % 3;
        if (mem_addr < 32'h400 && mem_addr[4:0] == 5'd0) begin
          last_w0 = mem_addr;
          if (mem_addr == watch) stop_reads++;
        end
      end
    end
    if (hold_low > 0) begin
      tx_ready = 1'b0;
      hold_low--;
    end else begin
      tx_ready = ($urandom % 3) != 0;
      if ($urandom % 16 == 0) hold_low = $urandom % 12;
    end
    if (tx_valid && tx_ready) begin
      gb[gn] = tx_data;
      gl[gn] = tx_last;
      gn++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic arm_slot(input int s, input int b1, input int b2, input int off,
                          input bit ls, input bit own, input logic [31:0] bufo);
    logic [31:0] d, a, c, r;
    d = RING + 32'(32 * s);
    a = (bufo != 0) ? bufo : 32'h400 + 32'(32'h100 * s) + 32'(off);
    c = $urandom;
    c[31] = own;
    c[29] = ls;
    c[21] = (s == SLOTS - 1);
    r = $urandom;
    mem[d[11:2]]       = c;
    mem[d[11:2] + 10'd1] = {r[31:28], 12'(b2), r[15:12], 12'(b1)};
    mem[d[11:2] + 10'd2] = a;
    for (int i = 3; i < 8; i++) mem[d[11:2] + 10'(i)] = $urandom;
    for (int i = 0; i < b1 + b2; i++) begin
      logic [31:0] x;
      x = a + 32'(i);
      mem[x[11:2]][{x[1:0], 3'b000} +: 8] = 8'($urandom);
    end
  endtask

  task automatic build_exp;
    logic [31:0] p, c, w1, a;
    int len;
    p = mptr; en = 0; ecount = 0; exp_ti = 0; exp_err = 0;
    while (mem[p[11:2]][31] && ecount < 16) begin
      c = mem[p[11:2]];
      w1 = mem[p[11:2] + 10'd1];
      a = mem[p[11:2] + 10'd2];
      len = int'(w1[11:0]) + int'(w1[27:16]);
      if (int'(w1[11:0]) > 2048 || w1[27:16] != 0) exp_err = 1;
      for (int i = 0; i < len; i++) begin
        eb[en] = mb(a + 32'(i));
        el[en] = c[29] && (i == len - 1);
        en++;
      end
      if (c[29]) exp_ti = 1;
      ep[ecount] = p;
      ectl[ecount] = c & 32'h7fff_ffff;
      ecount++;
      p = c[21] ? RING : p + 32'd32;
    end
    estop = p;
  endtask

  task automatic poll;
    @(negedge clk) poll_a = 1'b1;
    @(negedge clk) poll_a = 1'b0;
  endtask

  task automatic run_pass(input string nm, input int extra, input bit coincide, input int exp_stop);
    int mis;
    build_exp;
    watch = estop; stop_reads = 0; gn = 0; wr_cnt = 0;
    @(negedge clk) stat_clr = 3'b111;
    @(negedge clk) stat_clr = 3'b000;
    poe = coincide;
    poll;
    for (int k = 0; k < extra; k++) begin
      repeat (3) @(negedge clk);
      poll;
    end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk({"R4 byte count ", nm}, 64'(gn), 64'(en));
    mis = -1;
    for (int i = 0; i < en && i < gn; i++) if (mis < 0 && gb[i] !== eb[i]) mis = i;
    chk({"R4 byte data first mismatch ", nm}, 64'(mis), 64'(-1));
    mis = -1;
    for (int i = 0; i < en && i < gn; i++) if (mis < 0 && gl[i] !== el[i]) mis = i;
    chk({"R5 last marker first mismatch ", nm}, 64'(mis), 64'(-1));
    mis = -1;
    for (int i = 0; i < ecount; i++) if (mis < 0 && mem[ep[i][11:2]] !== ectl[i]) mis = i;
    chk({"R6 write-back first mismatch ", nm}, 64'(mis), 64'(-1));
    chk({"R6 write count ", nm}, 64'(wr_cnt), 64'(ecount));
    chk({"R7 stop pointer ", nm}, 64'(last_w0), 64'(estop));
    chk({"R3 R11 stop descriptor reads ", nm}, 64'(stop_reads), 64'(exp_stop));
    chk({"R8 ti ", nm}, 64'(stat_ti), 64'(exp_ti));
    chk({"R8 nis ", nm}, 64'(stat_nis), 64'(exp_ti));
    chk({"R9 err ", nm}, 64'(stat_err), 64'(exp_err));
    mptr = estop;
  endtask

  function automatic int slot_of(input logic [31:0] p);
    return int'((p - RING) >> 5);
  endfunction

  initial begin
    int k, s0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 64'(busy), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 busy after reset", 64'(busy), 64'd0);
    chk("R1 mem_req after reset", 64'(mem_req), 64'd0);
    chk("R1 tx_valid after reset", 64'(tx_valid), 64'd0);
    chk("R1 status after reset", 64'({stat_err, stat_nis, stat_ti}), 64'd0);

    // R2: base load, then a walk that meets a software-owned descriptor
    @(negedge clk) begin base_wr = 1'b1; base_addr = RING; end
    @(negedge clk) base_wr = 1'b0;
    mptr = RING;
    arm_slot(0, 5, 0, 0, 1'b1, 1'b0, 32'd0);
    run_pass("R2 R3 unowned head", 0, 1'b0, 1);
    chk("R2 first descriptor read at base", 64'(last_w0), 64'(RING));

    // random passes around the ring (R4 R5 R6 R7 R8)
    for (int it = 0; it < 20; it++) begin
      k = $urandom % 7;
      s0 = slot_of(mptr);
      for (int j = 0; j < k; j++)
        arm_slot((s0 + j) % SLOTS, 1 + ($urandom % 40), 0, $urandom % 4,
                 (j == k - 1) || ($urandom % 2 == 1), 1'b1, 32'd0);
      arm_slot((s0 + k) % SLOTS, 5, 0, 0, 1'b0, 1'b0, 32'd0);
      run_pass("random", 0, 1'b0, 1);
    end

    // R8: clear drops a set flag
    s0 = slot_of(mptr);
    arm_slot(s0, 3, 0, 1, 1'b1, 1'b1, 32'd0);
    arm_slot((s0 + 1) % SLOTS, 3, 0, 0, 1'b0, 1'b0, 32'd0);
    run_pass("R8 set", 0, 1'b0, 1);
    @(negedge clk) stat_clr = 3'b001;
    @(negedge clk) stat_clr = 3'b000;
    chk("R8 ti after clear", 64'(stat_ti), 64'd0);
    chk("R8 nis kept after ti clear", 64'(stat_nis), 64'd1);

    // R5: zero-length last segment
    s0 = slot_of(mptr);
    arm_slot(s0, 0, 0, 0, 1'b1, 1'b1, 32'd0);
    arm_slot((s0 + 1) % SLOTS, 3, 0, 0, 1'b0, 1'b0, 32'd0);
    run_pass("R5 zero length", 0, 1'b0, 1);

    // R9: secondary size non-zero, then a primary size above the limit
    s0 = slot_of(mptr);
    arm_slot(s0, 5, 3, 2, 1'b1, 1'b1, 32'd0);
    arm_slot((s0 + 1) % SLOTS, 3, 0, 0, 1'b0, 1'b0, 32'd0);
    run_pass("R9 size2", 0, 1'b0, 1);
    s0 = slot_of(mptr);
    arm_slot(s0, 2049, 0, 0, 1'b1, 1'b1, 32'h603);
    arm_slot((s0 + 1) % SLOTS, 3, 0, 0, 1'b0, 1'b0, 32'd0);
    run_pass("R9 size1 big", 0, 1'b0, 1);

    // R11: polls during a walk collapse into one extra pass
    s0 = slot_of(mptr);
    for (int j = 0; j < 4; j++) arm_slot((s0 + j) % SLOTS, 20, 0, j, 1'b1, 1'b1, 32'd0);
    arm_slot((s0 + 4) % SLOTS, 3, 0, 0, 1'b0, 1'b0, 32'd0);
    run_pass("R11 late polls", 2, 1'b0, 2);

    // R11: poll in the very cycle the ending descriptor arrives
    s0 = slot_of(mptr);
    for (int j = 0; j < 2; j++) arm_slot((s0 + j) % SLOTS, 6, 0, 1, 1'b1, 1'b1, 32'd0);
    arm_slot((s0 + 2) % SLOTS, 3, 0, 0, 1'b0, 1'b0, 32'd0);
    run_pass("R11 coincident", 0, 1'b1, 2);
    run_pass("R11 coincident empty", 0, 1'b1, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule